// File: doc/BRIEF.md
# Segment Translation and Protection Checker

This block turns a 16-bit segment selector and a 32-bit offset into a 32-bit linear address. Along the way it enforces segment protection. Two small descriptor tables, a global one and a local one, are loaded through a one-entry-per-cycle write port. Each entry holds a base, a limit, a code/data kind, a two-bit descriptor privilege level and a present flag.

Each request names the access kind: instruction fetch, data read, data write, or a stack-selector check. It also carries the current privilege level. One cycle later the block answers with a one-cycle valid strobe. When the request fails, the strobe comes with a fault flag and a three-bit cause. The linear address is driven only when the request passes every check. A fetch that passes also reports the privilege level the processor would adopt from that code selector.

Top module: `seg_xlate`

## Requirements
- R1: The selector is decoded as follows. Bits [1:0] are the requested level (RPL). Bit 2 picks the local table when 1 and the global table when 0. Bits [15:3] are the descriptor index.
- R2: An index of 16 or more faults with cause 5 (index).
- R3: A descriptor whose present flag is clear faults with cause 4 (absent).
- R4: A fetch needs a code descriptor, and a write or stack check needs a data descriptor; a read is accepted on either kind. Any other pairing faults with cause 2 (type). On the request side, kind 0 is fetch, 1 is read, 2 is write and 3 is stack check. In a descriptor, the kind bit is 1 for code.
- R5: This check covers reads, writes and stack checks. The effective level is the larger of the current level and the RPL. When that level exceeds the descriptor level, the access faults with cause 3 (privilege). Fetches skip this check.
- R6: A stack check whose RPL differs from the current level faults with cause 3.
- R7: An offset greater than or equal to the descriptor limit faults with cause 1 (limit).
- R8: An access that passes every check returns the linear address base + offset, modulo 2^32, with cause 0.
- R9: When several checks fail, the reported cause is chosen in this order of precedence: index, absent, type, privilege, limit.
- R10: A request accepted at a clock edge produces `out_valid` high for exactly the following cycle. Without a request, `out_valid` is low.
- R11: A faulting result has `out_fault` high and `out_lin` zero, and `out_fault` equals (cause != 0). The outputs are all zero in a cycle without a result.
- R12: On a passing fetch, `out_cpl` equals the selector's RPL. In every other result, `out_cpl` equals the request's current level.
- R13: Reset clears every table entry to not-present and every output to zero.
- R14: A descriptor written at a clock edge is seen by requests from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Descriptor write enable |
| wr_local | input | 1 | Write target: 1 local table, 0 global table |
| wr_idx | input | IDX_W | Entry written |
| wr_base | input | 32 | Segment base |
| wr_limit | input | 32 | Segment limit (exclusive) |
| wr_code | input | 1 | 1 code (read+execute), 0 data (read+write) |
| wr_dpl | input | 2 | Descriptor privilege level |
| wr_present | input | 1 | Present flag |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 stack check |
| req_cpl | input | 2 | Current privilege level |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_fault | output | 1 | Request refused |
| out_cause | output | 3 | 0 none, 1 limit, 2 type, 3 privilege, 4 absent, 5 index |
| out_lin | output | 32 | Linear address, zero on fault |
| out_cpl | output | 2 | Resulting privilege level |

## Verification
The assertions watch several rules on every cycle, none of which needs the table contents:
- a request is followed by exactly one strobe;
- a fault never carries an address;
- the fault flag and the cause agree;
- an out-of-range index always gives the index cause;
- a stack check with a mismatched RPL is always refused;
- a passing fetch hands its RPL to `out_cpl`.

Limit, type, privilege and address results depend on the stored descriptors. Only the bench's scenarios can show those, with its model of the tables. The same holds for the order of precedence when several checks fail, for the local/global choice, for address wrap-around and for write-then-use timing.

// File: rtl/seg_pkg.sv
package seg_pkg;

   localparam int SEG_AW  = 32;
   localparam int SEL_W   = 16;
   localparam int SIDX_W  = SEL_W - 3;
   localparam int CAUSE_W = 3;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_STACK = 2'd3
   } acc_kind_e;

   typedef enum logic [CAUSE_W-1:0] {
      FLT_NONE   = 3'd0,
      FLT_LIMIT  = 3'd1,
      FLT_TYPE   = 3'd2,
      FLT_PRIV   = 3'd3,
      FLT_ABSENT = 3'd4,
      FLT_INDEX  = 3'd5
   } flt_e;

   typedef struct packed {
      logic              present;
      logic              is_code;
      logic [1:0]        dpl;
      logic [SEG_AW-1:0] base;
      logic [SEG_AW-1:0] limit;
   } seg_desc_t;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
   import seg_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  seg_desc_t        wdesc,
   input  logic [IDX_W-1:0] ridx,
   output seg_desc_t        rdesc
);

   localparam int DEPTH = 1 << IDX_W;

   seg_desc_t mem [DEPTH];

   // R13: reset leaves every entry not-present; R14: write visible next cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[widx] <= wdesc;
      end
   end

   assign rdesc = mem[ridx];

endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_pkg::*;
(
   input  logic              idx_ok,
   input  seg_desc_t         desc,
   input  acc_kind_e         kind,
   input  logic [1:0]        rpl,
   input  logic [1:0]        cpl,
   input  logic [SEG_AW-1:0] off,
   output flt_e              cause,
   output logic [SEG_AW-1:0] lin,
   output logic [1:0]        cpl_next
);

   logic [1:0]        eff_pl;
   logic              type_bad;
   logic              priv_bad;
   logic              lim_bad;
   logic [SEG_AW-1:0] sum;

   always_comb begin
      eff_pl   = (rpl > cpl) ? rpl : cpl;
      // R4: fetch needs code, write/stack need data, read takes either
      type_bad = ((kind == ACC_FETCH) && !desc.is_code) ||
                 (((kind == ACC_WRITE) || (kind == ACC_STACK)) && desc.is_code);
      // R5/R6: weaker of the two levels against the descriptor level
      priv_bad = (kind != ACC_FETCH) &&
                 ((eff_pl > desc.dpl) || ((kind == ACC_STACK) && (rpl != cpl)));
      lim_bad  = (off >= desc.limit);
      sum      = desc.base + off;

      // R9: precedence index > absent > type > privilege > limit
      if (!idx_ok)            cause = FLT_INDEX;
      else if (!desc.present) cause = FLT_ABSENT;
      else if (type_bad)      cause = FLT_TYPE;
      else if (priv_bad)      cause = FLT_PRIV;
      else if (lim_bad)       cause = FLT_LIMIT;
      else                    cause = FLT_NONE;

      lin      = (cause == FLT_NONE) ? sum : '0;
      cpl_next = ((cause == FLT_NONE) && (kind == ACC_FETCH)) ? rpl : cpl;
   end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_local,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [SEG_AW-1:0]  wr_base,
   input  logic [SEG_AW-1:0]  wr_limit,
   input  logic               wr_code,
   input  logic [1:0]         wr_dpl,
   input  logic               wr_present,
   input  logic               req_valid,
   input  logic [SEL_W-1:0]   req_sel,
   input  logic [SEG_AW-1:0]  req_off,
   input  logic [1:0]         req_kind,
   input  logic [1:0]         req_cpl,
   output logic               out_valid,
   output logic               out_fault,
   output logic [CAUSE_W-1:0] out_cause,
   output logic [SEG_AW-1:0]  out_lin,
   output logic [1:0]         out_cpl
);

   localparam int NTBL = 2;

   if (IDX_W < 1 || IDX_W > SIDX_W) begin : g_bad_idx_w
      $error("seg_xlate: IDX_W must lie in 1..%0d", SIDX_W);
   end

   // R1: selector fields
   logic [1:0]        sel_rpl;
   logic              sel_local;
   logic [SIDX_W-1:0] sel_idx;
   logic              idx_ok;

   assign sel_rpl   = req_sel[1:0];
   assign sel_local = req_sel[2];
   assign sel_idx   = req_sel[SEL_W-1:3];
   assign idx_ok    = ((sel_idx >> IDX_W) == '0);   // R2

   seg_desc_t wdesc;
   seg_desc_t rd [NTBL];
   seg_desc_t desc;

   assign wdesc = '{present: wr_present, is_code: wr_code, dpl: wr_dpl,
                    base: wr_base, limit: wr_limit};

   for (genvar t = 0; t < NTBL; t++) begin : g_tbl
      localparam bit IS_LOCAL = (t == 1);
      seg_desc_table #(.IDX_W(IDX_W)) u_tbl (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_en && (wr_local == IS_LOCAL)),
         .widx  (wr_idx),
         .wdesc (wdesc),
         .ridx  (sel_idx[IDX_W-1:0]),
         .rdesc (rd[t])
      );
   end

   assign desc = sel_local ? rd[1] : rd[0];

   flt_e              chk_cause;
   logic [SEG_AW-1:0] chk_lin;
   logic [1:0]        chk_cpl;

   seg_check u_check (
      .idx_ok   (idx_ok),
      .desc     (desc),
      .kind     (acc_kind_e'(req_kind)),
      .rpl      (sel_rpl),
      .cpl      (req_cpl),
      .off      (req_off),
      .cause    (chk_cause),
      .lin      (chk_lin),
      .cpl_next (chk_cpl)
   );

   // R10/R11: registered result, zero when idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_fault <= 1'b0;
         out_cause <= '0;
         out_lin   <= '0;
         out_cpl   <= '0;
      end else begin
         out_valid <= req_valid;
         out_fault <= req_valid && (chk_cause != FLT_NONE);
         out_cause <= req_valid ? chk_cause : '0;
         out_lin   <= req_valid ? chk_lin   : '0;
         out_cpl   <= req_valid ? chk_cpl   : '0;
      end
   end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int IDX_W = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [15:0] req_sel,
   input logic [1:0]  req_kind,
   input logic [1:0]  req_cpl,
   input logic        out_valid,
   input logic        out_fault,
   input logic [2:0]  out_cause,
   input logic [31:0] out_lin,
   input logic [1:0]  out_cpl
);

   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);

   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid);

   a_r11_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
      out_fault |-> (out_valid && out_lin == 32'd0));

   a_r11_cause_agrees: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_fault == (out_cause != 3'd0)) && out_cause <= 3'd5));

   a_r2_index_range: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ((req_sel[15:3] >> IDX_W) != 13'd0)) |=> (out_fault && out_cause == 3'd5));

   a_r6_stack_match: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd3 && req_sel[1:0] != req_cpl) |=> out_fault);

   a_r12_fetch_cpl: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd0) |=> (out_fault || out_cpl == $past(req_sel[1:0])));

endmodule

bind seg_xlate seg_xlate_chk #(.IDX_W(IDX_W)) u_seg_xlate_chk (.*);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, wr_local, wr_code, wr_present;
   logic [3:0]  wr_idx;
   logic [31:0] wr_base, wr_limit;
   logic [1:0]  wr_dpl;
   logic        req_valid;
   logic [15:0] req_sel;
   logic [31:0] req_off;
   logic [1:0]  req_kind, req_cpl;
   logic        out_valid, out_fault;
   logic [2:0]  out_cause;
   logic [31:0] out_lin;
   logic [1:0]  out_cpl;

   always #4 clk = ~clk;   // 125 MHz

   seg_xlate #(.IDX_W(4)) dut (.*);

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // behavioural model of the two tables
   logic [31:0] m_base [2][16];
   logic [31:0] m_lim  [2][16];
   bit          m_code [2][16];
   bit          m_pres [2][16];
   logic [1:0]  m_dpl  [2][16];

   bit          e_valid, e_fault;
   int          e_cause;
   logic [31:0] e_lin;
   logic [1:0]  e_cpl;
   string       tag = "R13";

   function automatic logic [15:0] mk_sel(int idx, bit loc, logic [1:0] rpl);
      return {idx[12:0], loc, rpl};
   endfunction

   task automatic model();
      int idx, t, c;
      logic [1:0] r, eff;
      e_valid = req_valid; e_fault = 0; e_cause = 0; e_lin = '0; e_cpl = '0;
      if (req_valid) begin
         idx = int'(req_sel[15:3]); t = int'(req_sel[2]); r = req_sel[1:0];
         eff = (r > req_cpl) ? r : req_cpl;
         if (idx >= 16) c = 5;
         else if (!m_pres[t][idx]) c = 4;
         else if ((req_kind == 2'd0 && !m_code[t][idx]) ||
                  ((req_kind == 2'd2 || req_kind == 2'd3) && m_code[t][idx])) c = 2;
         else if (req_kind != 2'd0 && (eff > m_dpl[t][idx] ||
                  (req_kind == 2'd3 && r != req_cpl))) c = 3;
         else if (req_off >= m_lim[t][idx]) c = 1;
         else c = 0;
         e_cause = c;
         e_fault = (c != 0);
         e_lin   = (c == 0) ? m_base[t][idx] + req_off : 32'd0;
         e_cpl   = (c == 0 && req_kind == 2'd0) ? r : req_cpl;
      end
      if (wr_en) begin
         m_base[wr_local][wr_idx] = wr_base;
         m_lim [wr_local][wr_idx] = wr_limit;
         m_code[wr_local][wr_idx] = wr_code;
         m_pres[wr_local][wr_idx] = wr_present;
         m_dpl [wr_local][wr_idx] = wr_dpl;
      end
   endtask

   task automatic compare();
      n_chk++;
      if (out_valid !== e_valid || out_fault !== e_fault || int'(out_cause) != e_cause ||
          out_lin !== e_lin || out_cpl !== e_cpl) begin
         n_bad++;
         $display("FAIL %s: got v%0d f%0d c%0d lin=%h cpl%0d exp v%0d f%0d c%0d lin=%h cpl%0d",
                  tag, out_valid, out_fault, out_cause, out_lin, out_cpl,
                  e_valid, e_fault, e_cause, e_lin, e_cpl);
      end
   endtask

   // inputs are set at a falling edge; the result is compared at the next one
   task automatic step();
      model();
      @(negedge clk);
      compare();
   endtask

   task automatic wr(bit loc, int idx, logic [31:0] b, logic [31:0] l, bit code,
                     logic [1:0] dpl, bit pres);
      wr_en = 1; wr_local = loc; wr_idx = idx[3:0]; wr_base = b; wr_limit = l;
      wr_code = code; wr_dpl = dpl; wr_present = pres; req_valid = 0;
      step();
      wr_en = 0;
   endtask

   task automatic rq(string t, logic [15:0] s, logic [31:0] o, logic [1:0] k,
                     logic [1:0] c);
      tag = t; wr_en = 0;
      req_valid = 1; req_sel = s; req_off = o; req_kind = k; req_cpl = c;
      step();
   endtask

   task automatic idle(string t);
      tag = t; wr_en = 0; req_valid = 0;
      step();
   endtask

   initial begin
      for (int t = 0; t < 2; t++)
         for (int i = 0; i < 16; i++) begin
            m_base[t][i] = '0; m_lim[t][i] = '0; m_code[t][i] = 0;
            m_pres[t][i] = 0;  m_dpl[t][i] = '0;
         end
      rst_n = 0; wr_en = 0; wr_local = 0; wr_idx = '0; wr_base = '0; wr_limit = '0;
      wr_code = 0; wr_dpl = '0; wr_present = 0;
      req_valid = 0; req_sel = '0; req_off = '0; req_kind = '0; req_cpl = '0;
      repeat (3) @(negedge clk);
      // R13: outputs zero under reset
      n_chk++;
      if (out_valid || out_fault || out_cause != 0 || out_lin != 0 || out_cpl != 0) begin
         n_bad++;
         $display("FAIL R13: reset outputs v%0d f%0d c%0d lin=%h cpl%0d exp all zero",
                  out_valid, out_fault, out_cause, out_lin, out_cpl);
      end
      rst_n = 1;
      idle("R13");
      rq("R13", mk_sel(0, 1, 0), 32'h0, 2'd1, 2'd0);       // empty entry: absent
      rq("R3",  mk_sel(9, 0, 0), 32'h0, 2'd1, 2'd0);

      // table contents
      wr(0, 1, 32'h0000_1000, 32'h0000_0100, 0, 2'd0, 1);
      rq("R14", mk_sel(1, 0, 0), 32'h10, 2'd1, 2'd0);     // used next cycle
      wr(0, 2, 32'hCAFE_0000, 32'h0000_8000, 1, 2'd3, 1);
      wr(0, 3, 32'hFFFF_FF00, 32'hFFFF_FFFF, 0, 2'd3, 1);
      wr(1, 5, 32'h0000_0020, 32'h0000_0040, 1, 2'd0, 1);
      wr(1, 6, 32'h0000_4000, 32'h0000_0010, 0, 2'd0, 0);

      // R8: address formation and wrap
      rq("R8", mk_sel(1, 0, 0), 32'h0000_00FF, 2'd2, 2'd0);
      rq("R8", mk_sel(3, 0, 3), 32'h0000_0200, 2'd1, 2'd3);
      rq("R8", mk_sel(2, 0, 3), 32'h0000_0100, 2'd0, 2'd3);
      // R7: limit is exclusive
      rq("R7", mk_sel(1, 0, 0), 32'h0000_0100, 2'd1, 2'd0);
      rq("R7", mk_sel(5, 1, 0), 32'h0000_0040, 2'd0, 2'd0);
      // R1: local vs global with the same index
      rq("R1", mk_sel(5, 0, 0), 32'h0, 2'd0, 2'd0);
      rq("R1", mk_sel(5, 1, 0), 32'h4, 2'd0, 2'd0);
      // R4: type rules
      rq("R4", mk_sel(1, 0, 0), 32'h0, 2'd0, 2'd0);
      rq("R4", mk_sel(2, 0, 3), 32'h0, 2'd2, 2'd3);
      rq("R4", mk_sel(2, 0, 3), 32'h0, 2'd1, 2'd3);
      rq("R4", mk_sel(5, 1, 0), 32'h0, 2'd3, 2'd0);
      // R5: effective level
      rq("R5", mk_sel(1, 0, 3), 32'h0, 2'd1, 2'd0);
      rq("R5", mk_sel(1, 0, 0), 32'h0, 2'd2, 2'd3);
      rq("R5", mk_sel(1, 0, 0), 32'h0, 2'd2, 2'd0);
      rq("R5", mk_sel(3, 0, 0), 32'h0, 2'd1, 2'd2);
      // R6: stack selector level must match
      rq("R6", mk_sel(3, 0, 2), 32'h0, 2'd3, 2'd3);
      rq("R6", mk_sel(3, 0, 3), 32'h0, 2'd3, 2'd3);
      // R2: index range
      rq("R2", mk_sel(16, 0, 0), 32'h0, 2'd1, 2'd0);
      rq("R2", mk_sel(13'h1FFF, 1, 3), 32'h0, 2'd0, 2'd3);
      // R3 / R9: precedence
      rq("R9", mk_sel(6, 1, 3), 32'hFFFF_FFFF, 2'd0, 2'd3);
      rq("R9", mk_sel(2, 0, 3), 32'h0, 2'd2, 2'd0);
      rq("R9", mk_sel(1, 0, 3), 32'hFFFF_0000, 2'd1, 2'd0);
      // R12: fetch adopts the selector level; faults keep the current level
      rq("R12", mk_sel(2, 0, 3), 32'h10, 2'd0, 2'd0);
      rq("R12", mk_sel(2, 0, 1), 32'h9000, 2'd0, 2'd2);
      // R10/R11: idle gap between requests
      idle("R10");
      rq("R10", mk_sel(1, 0, 0), 32'h20, 2'd1, 2'd0);
      idle("R11");

      // mixed traffic
      for (int n = 0; n < 600; n++) begin
         if ($urandom_range(0, 7) == 0)
            wr(1'($urandom_range(0, 1)), $urandom_range(0, 15), $urandom,
               $urandom_range(0, 4) == 0 ? 32'hFFFF_FFFF : $urandom_range(0, 512),
               1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
               $urandom_range(0, 5) != 0);
         else if ($urandom_range(0, 9) == 0)
            idle("R10");
         else
            rq("R9", mk_sel($urandom_range(0, 19), 1'($urandom_range(0, 1)),
                            2'($urandom_range(0, 3))),
               $urandom_range(0, 600), 2'($urandom_range(0, 3)),
               2'($urandom_range(0, 3)));
      end
      idle("R10");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got running exp finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule